// File: doc/BRIEF.md
# Rotated-Parity Small-Write Sequencer

This block carries out single-block writes into a five-disk striped array whose parity block changes disk from one stripe row to the next. A request gives a logical block number and a data word. The block works out the stripe row, the disk that holds that data block and the disk that holds the row's parity. It then reads what it needs, forms the new parity and writes the new data and the new parity. Each disk has its own request/acknowledge port, and a shared row bus gives the row address for that disk port.

There are two ways to form the parity. In the default mode the block reads the old data and the old parity, then XORs them with the new data. In this mode the other data disks stay idle. In reconstruct mode the block reads the three other data blocks of the row instead, and the new parity is their XOR with the new data. In both modes every read must finish before the data write and the parity write are issued together. A busy flag rejects new requests until both writes are acknowledged, and a done pulse marks the end of the operation.

Top module: `rot_parity_writer`

## Requirements
- R1: Disks are numbered 0 to 4, and bit i of every per-disk vector belongs to disk i. Logical block n lies in row n/4 at data slot n mod 4. The row's parity is on disk 4 − (row mod 5). Data slots 0..3 take the remaining disks in ascending order. Only the data disk and the parity disk are written.
- R2: In default mode the block makes exactly one read of the target data disk and one read of the parity disk, and it reads no other disk.
- R3: The data disk receives the new data. In default mode the parity disk receives old parity XOR old data XOR new data.
- R4: Writes start only after every read of the operation has been acknowledged. The data write and the parity write are raised in the same cycle, and no write is raised while a read request is still outstanding.
- R5: With reqRecon set, the block reads only the three other data disks of the row, once each. The parity disk then receives the XOR of those three values and the new data.
- R6: busy goes high in the cycle after a request is accepted and stays high until both write acknowledges have returned. A reqValid that arrives while busy is high is ignored and changes no disk.
- R7: done is a one-cycle pulse in the first cycle in which busy is low again after an operation.
- R8: While rstN is low, busy, done and every diskReq bit are low. This also holds when reset arrives in the middle of an operation, and the next request after reset is served normally.
- R9: A disk request stays high until that disk acknowledges it and drops in the following cycle. diskWe marks a write, and diskRow holds its value while any request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Single-cycle write request strobe |
| reqLba | input | LBA_W | Logical block number |
| reqData | input | DATA_W | New data word |
| reqRecon | input | 1 | 1 = reconstruct mode, 0 = read-modify-write |
| busy | output | 1 | Operation in progress; requests are ignored |
| done | output | 1 | One-cycle completion pulse |
| diskReq | output | NUM_DISKS | Per-disk access request |
| diskWe | output | NUM_DISKS | Per-disk write flag (valid with diskReq) |
| diskRow | output | LBA_W | Stripe row addressed on every disk |
| diskWdata | output | NUM_DISKS*DATA_W | Per-disk write data, disk i at bits i*DATA_W |
| diskAck | input | NUM_DISKS | Per-disk one-cycle acknowledge |
| diskRdata | input | NUM_DISKS*DATA_W | Per-disk read data, valid with diskAck |

## Verification
The checker assumes that each disk acknowledges a request once, for a single cycle, and only while that request is high. It also assumes that a request is presented as a one-cycle reqValid strobe. The disk models in the bench count their own latency while a request is raised, return one acknowledge and then wait for the request to drop, so they always meet these assumptions. Each disk has its own latency, which the bench changes between scenarios. This makes read acknowledges arrive either in separate cycles or in the same cycle.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE_RD,
    ST_WAIT_RD,
    ST_WAIT_WR
  } seqState_t;

  typedef struct packed {
    logic load;        // capture request and mapping
    logic issueRead;   // launch read phase
    logic issueWrite;  // launch paired writes
    logic finish;      // operation complete
  } seqStrobe_t;

endpackage

// File: rtl/rps_map.sv
// Logical block -> (row, data disk, parity disk) with rotating parity.
module rps_map #(
  parameter int NUM_DISKS = 5,
  parameter int LBA_W     = 16,
  localparam int DATA_DISKS = NUM_DISKS - 1,
  localparam int DISK_W     = $clog2(NUM_DISKS)
) (
  input  logic [LBA_W-1:0]  lba,
  output logic [LBA_W-1:0]  row,
  output logic [DISK_W-1:0] dataDisk,
  output logic [DISK_W-1:0] parDisk
);

  logic [LBA_W-1:0]  slotW;
  logic [LBA_W-1:0]  rowMod;
  logic [DISK_W-1:0] slot;

  always_comb begin
    row      = lba / LBA_W'(DATA_DISKS);
    slotW    = lba % LBA_W'(DATA_DISKS);
    rowMod   = row % LBA_W'(NUM_DISKS);
    slot     = DISK_W'(slotW);
    parDisk  = DISK_W'(NUM_DISKS - 1) - DISK_W'(rowMod);
    dataDisk = (slot < parDisk) ? slot : slot + DISK_W'(1);
  end

endmodule

// File: rtl/rps_ctrl.sv
// Sequencing FSM: accept, read phase, paired write phase, completion.
module rps_ctrl
  import rps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       pendEmpty,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  seqState_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          nextState   = ST_ISSUE_RD;
        end
      end
      ST_ISSUE_RD: begin
        strobe.issueRead = 1'b1;
        nextState        = ST_WAIT_RD;
      end
      ST_WAIT_RD: begin
        if (pendEmpty) begin
          strobe.issueWrite = 1'b1;
          nextState         = ST_WAIT_WR;
        end
      end
      ST_WAIT_WR: begin
        if (pendEmpty) begin
          strobe.finish = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= strobe.finish;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/rps_datapath.sv
// Request capture, outstanding-request tracking and parity accumulation.
module rps_datapath
  import rps_pkg::*;
#(
  parameter int NUM_DISKS = 5,
  parameter int DATA_W    = 32,
  parameter int LBA_W     = 16,
  localparam int DISK_W   = $clog2(NUM_DISKS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  seqStrobe_t                  strobe,
  input  logic [LBA_W-1:0]            reqLba,
  input  logic [DATA_W-1:0]           reqData,
  input  logic                        reqRecon,
  output logic                        pendEmpty,
  output logic [NUM_DISKS-1:0]        diskReq,
  output logic [NUM_DISKS-1:0]        diskWe,
  output logic [LBA_W-1:0]            diskRow,
  output logic [NUM_DISKS*DATA_W-1:0] diskWdata,
  input  logic [NUM_DISKS-1:0]        diskAck,
  input  logic [NUM_DISKS*DATA_W-1:0] diskRdata
);

  logic [LBA_W-1:0]     mapRow;
  logic [DISK_W-1:0]    mapData, mapPar;
  logic [LBA_W-1:0]     rowReg;
  logic [DISK_W-1:0]    dataDisk, parDisk;
  logic [DATA_W-1:0]    newData, acc, ackXor;
  logic                 recon, wrPhase;
  logic [NUM_DISKS-1:0] pend, dataOh, parOh, writeMask, readMask, ackHit;

  rps_map #(.NUM_DISKS(NUM_DISKS), .LBA_W(LBA_W)) uMap (
    .lba      (reqLba),
    .row      (mapRow),
    .dataDisk (mapData),
    .parDisk  (mapPar)
  );

  always_comb begin
    dataOh    = NUM_DISKS'(1) << dataDisk;
    parOh     = NUM_DISKS'(1) << parDisk;
    writeMask = dataOh | parOh;
    readMask  = recon ? ~writeMask : writeMask;
    ackHit    = pend & diskAck;
  end

  always_comb begin
    ackXor = '0;
    for (int d = 0; d < NUM_DISKS; d++) begin
      if (ackHit[d]) ackXor = ackXor ^ diskRdata[d*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg   <= '0;
      dataDisk <= '0;
      parDisk  <= '0;
      newData  <= '0;
      recon    <= 1'b0;
    end else if (strobe.load) begin
      rowReg   <= mapRow;
      dataDisk <= mapData;
      parDisk  <= mapPar;
      newData  <= reqData;
      recon    <= reqRecon;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend    <= '0;
      wrPhase <= 1'b0;
    end else if (strobe.issueRead) begin
      pend    <= readMask;
      wrPhase <= 1'b0;
    end else if (strobe.issueWrite) begin
      pend    <= writeMask;
      wrPhase <= 1'b1;
    end else begin
      pend <= pend & ~diskAck;
      if (strobe.finish) wrPhase <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (strobe.load) begin
      acc <= reqData;
    end else if (!wrPhase) begin
      acc <= acc ^ ackXor;
    end
  end

  assign pendEmpty = (pend == '0);
  assign diskReq   = pend;
  assign diskWe    = wrPhase ? pend : '0;
  assign diskRow   = rowReg;

  for (genvar d = 0; d < NUM_DISKS; d++) begin : gWdata
    assign diskWdata[d*DATA_W +: DATA_W] =
        (DISK_W'(d) == parDisk)  ? acc :
        (DISK_W'(d) == dataDisk) ? newData : '0;
  end

endmodule

// File: rtl/rot_parity_writer.sv
module rot_parity_writer
  import rps_pkg::*;
#(
  parameter int NUM_DISKS = 5,
  parameter int DATA_W    = 32,
  parameter int LBA_W     = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [LBA_W-1:0]            reqLba,
  input  logic [DATA_W-1:0]           reqData,
  input  logic                        reqRecon,
  output logic                        busy,
  output logic                        done,
  output logic [NUM_DISKS-1:0]        diskReq,
  output logic [NUM_DISKS-1:0]        diskWe,
  output logic [LBA_W-1:0]            diskRow,
  output logic [NUM_DISKS*DATA_W-1:0] diskWdata,
  input  logic [NUM_DISKS-1:0]        diskAck,
  input  logic [NUM_DISKS*DATA_W-1:0] diskRdata
);

  seqStrobe_t strobe;
  logic       pendEmpty;

  rps_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .pendEmpty (pendEmpty),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done)
  );

  rps_datapath #(.NUM_DISKS(NUM_DISKS), .DATA_W(DATA_W), .LBA_W(LBA_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqLba    (reqLba),
    .reqData   (reqData),
    .reqRecon  (reqRecon),
    .pendEmpty (pendEmpty),
    .diskReq   (diskReq),
    .diskWe    (diskWe),
    .diskRow   (diskRow),
    .diskWdata (diskWdata),
    .diskAck   (diskAck),
    .diskRdata (diskRdata)
  );

endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
  parameter int NUM_DISKS = 5,
  parameter int LBA_W     = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 busy,
  input logic                 done,
  input logic [NUM_DISKS-1:0] diskReq,
  input logic [NUM_DISKS-1:0] diskWe,
  input logic [NUM_DISKS-1:0] diskAck,
  input logic [LBA_W-1:0]     diskRow
);

  assert_write_pair_R4: assert property (@(posedge clk) disable iff (!rstN)
    (diskWe != '0 && $past(diskWe) == '0) |-> $countones(diskWe) == 2);

  assert_reads_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    (diskWe != '0 && $past(diskWe) == '0) |-> $past(diskReq) == '0);

  assert_read_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    (diskReq != '0 && diskWe == '0) |-> $countones(diskReq) <= 3);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> diskReq == '0);

  assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(diskReq) & ~$past(diskAck) & ~diskReq) == '0);

  assert_row_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (diskReq != '0 && $past(diskReq) != '0) |-> $stable(diskRow));

endmodule

bind rot_parity_writer rps_checker #(.NUM_DISKS(NUM_DISKS), .LBA_W(LBA_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .busy     (busy),
  .done     (done),
  .diskReq  (diskReq),
  .diskWe   (diskWe),
  .diskAck  (diskAck),
  .diskRow  (diskRow)
);

// File: tb/rot_parity_writer_test.sv
module rot_parity_writer_test;
  localparam int ND = 5, DW = 32, LW = 16, ROWS = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic             reqValid = 1'b0, reqRecon = 1'b0;
  logic [LW-1:0]    reqLba = '0;
  logic [DW-1:0]    reqData = '0;
  logic             busy, done;
  logic [ND-1:0]    diskReq, diskWe;
  logic [LW-1:0]    diskRow;
  logic [ND*DW-1:0] diskWdata;
  logic [ND-1:0]    ackR;
  logic [ND*DW-1:0] rdR;

  rot_parity_writer uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLba(reqLba),
    .reqData(reqData), .reqRecon(reqRecon), .busy(busy), .done(done),
    .diskReq(diskReq), .diskWe(diskWe), .diskRow(diskRow),
    .diskWdata(diskWdata), .diskAck(ackR), .diskRdata(rdR)
  );

  logic [DW-1:0] mem [ND][ROWS];
  logic [DW-1:0] shadow [ND][ROWS];
  int lat [ND];
  int cnt [ND];
  int rdCnt [ND];
  int wrCnt [ND];
  int wrRise [ND];
  logic [ND-1:0] weQ;
  int cyc = 0;
  int mixViol = 0;
  logic benchInit = 1'b1;
  int nTests = 0, nFail = 0;

  function automatic logic [DW-1:0] pat(int d, int r);
    return 32'hA5C30000 ^ (d << 20) ^ (r * 32'h01030507);
  endfunction

  // Disk models: count latency while request is high, ack once, wait for drop.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    weQ <= diskWe;
    if (diskWe != '0 && (diskReq & ~diskWe) != '0) mixViol <= mixViol + 1;
    for (int d = 0; d < ND; d++) begin
      if (diskWe[d] && !weQ[d]) wrRise[d] <= cyc;
    end
    if (benchInit) begin
      for (int d = 0; d < ND; d++) begin
        rdCnt[d] <= 0; wrCnt[d] <= 0; wrRise[d] <= 0;
        for (int r = 0; r < ROWS; r++) mem[d][r] <= pat(d, r);
      end
    end
    if (!rstN) begin
      ackR <= '0;
      for (int d = 0; d < ND; d++) cnt[d] <= 0;
    end else begin
      for (int d = 0; d < ND; d++) begin
        if (ackR[d]) ackR[d] <= 1'b0;
        else if (diskReq[d]) begin
          if (cnt[d] >= lat[d]) begin
            ackR[d] <= 1'b1;
            cnt[d]  <= 0;
            if (diskWe[d]) begin
              mem[d][diskRow[3:0]] <= diskWdata[d*DW +: DW];
              wrCnt[d] <= wrCnt[d] + 1;
            end else begin
              rdR[d*DW +: DW] <= mem[d][diskRow[3:0]];
              rdCnt[d] <= rdCnt[d] + 1;
            end
          end else cnt[d] <= cnt[d] + 1;
        end
      end
    end
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkAllMem(string req);
    int bad = 0;
    for (int d = 0; d < ND; d++)
      for (int r = 0; r < ROWS; r++)
        if (mem[d][r] !== shadow[d][r]) bad++;
    check(bad == 0, req, "disk contents vs model (mismatches)", bad, 0);
  endtask

  // One small write; intr >= 0 pulses a second request while busy.
  task automatic doWrite(int lba, logic [DW-1:0] data, bit recon, int intr);
    int row = lba / 4;
    int slot = lba % 4;
    int par = 4 - (row % 5);
    int dd = (slot < par) ? slot : slot + 1;
    int rd0 [ND];
    int wr0 [ND];
    int mix0 = mixViol;
    int n = 0;
    logic [DW-1:0] expPar;
    for (int d = 0; d < ND; d++) begin rd0[d] = rdCnt[d]; wr0[d] = wrCnt[d]; end
    @(negedge clk);
    reqValid = 1'b1; reqLba = LW'(lba); reqData = data; reqRecon = recon;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R6", "busy after accept", busy, 1);
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
      if (intr >= 0 && n == 2) begin
        check(busy == 1'b1, "R6", "busy before intruder", busy, 1);
        reqValid = 1'b1; reqLba = LW'(intr); reqData = ~data; reqRecon = 1'b0;
      end else reqValid = 1'b0;
    end
    reqValid = 1'b0;
    check(done == 1'b1, "R7", "done seen before timeout", done, 1);
    check(busy == 1'b0, "R7", "busy low with done", busy, 0);
    if (recon) begin
      expPar = data;
      for (int d = 0; d < ND; d++) if (d != dd && d != par) expPar ^= shadow[d][row];
    end else expPar = shadow[par][row] ^ shadow[dd][row] ^ data;
    shadow[dd][row]  = data;
    shadow[par][row] = expPar;
    check(mem[dd][row] === data, "R3", "data disk content", mem[dd][row], data);
    check(mem[par][row] === expPar, recon ? "R5" : "R3", "parity disk content",
          mem[par][row], expPar);
    checkAllMem("R1");
    for (int d = 0; d < ND; d++) begin
      int expRd = recon ? ((d != dd && d != par) ? 1 : 0) : ((d == dd || d == par) ? 1 : 0);
      int expWr = (d == dd || d == par) ? 1 : 0;
      check(rdCnt[d] - rd0[d] == expRd, recon ? "R5" : "R2", $sformatf("reads on disk %0d", d),
            rdCnt[d] - rd0[d], expRd);
      check(wrCnt[d] - wr0[d] == expWr, "R1", $sformatf("writes on disk %0d", d),
            wrCnt[d] - wr0[d], expWr);
    end
    check(wrRise[dd] == wrRise[par], "R4", "data and parity writes same cycle",
          wrRise[dd], wrRise[par]);
    check(mixViol == mix0, "R4", "write raised with read outstanding", mixViol - mix0, 0);
    @(negedge clk);
    check(done == 1'b0, "R7", "done is one cycle", done, 0);
    check(busy == 1'b0, "R6", "no second operation started", busy, 0);
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R8", "busy in reset", busy, 0);
    check(done == 1'b0, "R8", "done in reset", done, 0);
    check(diskReq == '0, "R8", "diskReq in reset", diskReq, 0);
  endtask

  task automatic t_resetMid();
    for (int d = 0; d < ND; d++) lat[d] = 5;
    @(negedge clk);
    reqValid = 1'b1; reqLba = 16'd33; reqData = 32'h0BADF00D; reqRecon = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    check(diskReq != '0, "R9", "reads outstanding before reset", diskReq, 1);
    rstN = 1'b0;
    #1;
    check(diskReq == '0, "R8", "diskReq dropped by reset", diskReq, 0);
    check(busy == 1'b0, "R8", "busy cleared by reset", busy, 0);
    check(done == 1'b0, "R8", "done low in reset", done, 0);
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checkAllMem("R8");
    for (int d = 0; d < ND; d++) lat[d] = d + 1;
    doWrite(33, 32'h0BADF00D, 1'b0, -1);
  endtask

  initial begin
    for (int d = 0; d < ND; d++) begin
      lat[d] = d + 1;
      for (int r = 0; r < ROWS; r++) shadow[d][r] = pat(d, r);
    end
    repeat (3) @(negedge clk);
    benchInit = 1'b0;
    t_reset();
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    doWrite(0,  32'h12345678, 1'b0, -1);
    doWrite(5,  32'hCAFEBABE, 1'b0, -1);
    doWrite(7,  32'h00FF00FF, 1'b0, -1);
    doWrite(10, 32'hDEADBEEF, 1'b0, -1);
    doWrite(19, 32'h13579BDF, 1'b0, -1);
    doWrite(20, 32'h2468ACE0, 1'b0, -1);
    doWrite(6,  32'hFEEDFACE, 1'b1, -1);
    doWrite(17, 32'h0F0F1234, 1'b1, -1);
    for (int d = 0; d < ND; d++) lat[d] = 2;
    doWrite(5,  32'h55AA55AA, 1'b0, -1);
    doWrite(58, 32'hA1B2C3D4, 1'b1, -1);
    for (int d = 0; d < ND; d++) lat[d] = 4 - d;
    doWrite(40, 32'h77777777, 1'b0, 44);
    t_resetMid();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule